// File: doc/BRIEF.md
# Two-Tone FSK Carrier Modulator

This block turns a serial bit stream into a frequency-shift-keyed square wave for a slow, half-duplex carrier link working near 130 kHz. A numerically controlled oscillator (a phase accumulator clocked from the fixed system clock) produces the carrier. The most significant bit of the accumulator is the output pin. A one bit uses the high tone at 133.3 kHz. A zero bit uses a lower tone, and a configuration input picks that tone from two nearby frequencies.

A bit-period counter sets the symbol timing. Its period comes from a 2-bit rate select that chooses 600, 1200, 1800 or 2400 bit/s. Bits enter on a valid/ready handshake, and ready rises only at a bit boundary. Rate and tone configuration is sampled only while the transmitter is gated off, so a packet always goes out with one fixed setting. Gating the transmitter off silences the output and returns the oscillator to phase zero. The next packet therefore starts cleanly.

Top module: `fsk_mod`

## Requirements
- R1: While reset is low, fsk_out and bit_ready are low when tx_en is low. If tx_en is held high through reset, the first packet after reset uses the reset configuration: rate code 2'b11 (2400 bit/s) and the 131.8 kHz low tone. This holds whatever rate_sel and tone_sel show.
- R2: A bit lasts P = floor(CLK_HZ / (600 * (k + 1))) clock cycles, where k is the unsigned rate code (00 = 600, 01 = 1200, 10 = 1800, 11 = 2400 bit/s). Bits offered back to back give one bit_ready cycle every P cycles.
- R3: The accumulator is ACC_W = 32 bits wide. It adds step = round(f * 2^32 / CLK_HZ) once per cycle, and fsk_out is its top bit. A data bit of 1 uses f = 133.3 kHz. A data bit of 0 uses f = 131.8 kHz when tone_sel is 0 and f = 130.4 kHz when tone_sel is 1.
- R4: A new step takes effect on the clock edge that accepts the bit (bit_valid and bit_ready both high). Each accepted bit adds its step exactly P times. The accumulator is never cleared between bits, so the phase stays continuous across tone changes.
- R5: If no bit is offered at a boundary, bit_ready stays high and the accumulator holds its value until a bit is accepted.
- R6: If tx_en is sampled low at a clock edge, fsk_out is low and the accumulator is zero from the next cycle. Any bit in progress is abandoned. The next enable starts at phase zero with bit_ready high.
- R7: rate_sel and tone_sel are sampled only on edges where tx_en is low. Changes made while tx_en is high have no effect on the packet in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit gate; high while a packet is sent |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | Value of the offered bit |
| bit_ready | output | 1 | High at a bit boundary; a bit is taken when valid is also high |
| rate_sel | input | 2 | Bit-rate code, sampled while idle |
| tone_sel | input | 1 | Low-tone select, sampled while idle |
| fsk_out | output | 1 | Square-wave FSK carrier |

## Verification
The bench builds the block with CLK_HZ = 1_200_000 and every other parameter at its default. This makes the four bit periods 2000, 1000, 666 and 500 cycles, so packets at every rate fit in a short run. The 1800 bit/s code exercises the truncating division in the period. At this clock each tone step is about a ninth of the accumulator range. The output therefore toggles every four to five cycles, and comparing fsk_out on every cycle exposes a wrong step, a missing increment, or a phase reset at a bit boundary within a few cycles. Stalls, aborts and configuration changes mid-packet are all driven at these sizes.

// File: rtl/fsk_pkg.sv
`timescale 1ns/1ps
// fsk_pkg: shared types and constant functions for the FSK modulator.
// Assumes frequencies are given in units of 0.1 Hz and the accumulator
// is no wider than 40 bits, so the step computation fits in 64 bits.
package fsk_pkg;

    // Bit-rate codes; the numeric value k gives rate 600*(k+1) bit/s.
    typedef enum logic [1:0] {
        RATE_600  = 2'd0,
        RATE_1200 = 2'd1,
        RATE_1800 = 2'd2,
        RATE_2400 = 2'd3
    } rate_e;

    // Configuration captured while the transmitter is idle.
    typedef struct packed {
        rate_e rate;
        logic  space_alt;
    } fsk_cfg_t;

    localparam fsk_cfg_t CFG_RESET = '{rate: RATE_2400, space_alt: 1'b0};

    // Rounded phase step for a tone of f_dhz (0.1 Hz units).
    function automatic longint unsigned phase_step(
        input longint unsigned f_dhz,
        input longint unsigned clk_hz,
        input int unsigned     acc_w
    );
        longint unsigned num;
        longint unsigned den;
        num = (f_dhz << acc_w) + (64'd5 * clk_hz);
        den = 64'd10 * clk_hz;
        return num / den;
    endfunction

endpackage

// File: rtl/fsk_cfg_latch.sv
`timescale 1ns/1ps
// fsk_cfg_latch: follows rate and tone inputs while the transmitter is
// idle and freezes them while tx_en is high.
// Assumes inputs are synchronous to clk.
module fsk_cfg_latch
    import fsk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic [1:0] rate_sel,
    input  logic       tone_sel,
    output fsk_cfg_t   cfg_q
);

    // Capture configuration only on idle edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (!tx_en) begin
            cfg_q <= '{rate: rate_e'(rate_sel), space_alt: tone_sel};
        end
    end

endmodule

// File: rtl/fsk_bit_timer.sv
`timescale 1ns/1ps
// fsk_bit_timer: counts bit periods and runs the input handshake.
// Ready is high when enabled and the counter is zero. An accepted bit
// reloads the counter with its period minus one. The sending flag marks
// the cycles in which the oscillator must advance.
// Assumes each period is at least 2 cycles.
module fsk_bit_timer #(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned BASE_BPS  = 600,
    parameter int unsigned NUM_RATES = 4,
    parameter int unsigned RIDX_W    = 2,
    parameter int unsigned CNT_W     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [RIDX_W-1:0] rate_idx,
    input  logic              bit_valid,
    output logic              bit_ready,
    output logic              bit_load,
    output logic              sending,
    output logic [CNT_W-1:0]  cnt
);

    logic [CNT_W-1:0] period_tbl [NUM_RATES];
    logic [CNT_W-1:0] cur_period;

    // One period constant for each rate code.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_period
        localparam int unsigned BIT_CYC = CLK_HZ / (BASE_BPS * (g + 1));
        assign period_tbl[g] = CNT_W'(BIT_CYC);
    end

    // Period selected by the frozen rate code.
    assign cur_period = period_tbl[rate_idx];

    // Handshake at the boundary.
    assign bit_ready = tx_en && (cnt == '0);
    assign bit_load  = bit_ready && bit_valid;

    // Down-counter for the cycles left in the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            cnt <= '0;
        end else if (bit_load) begin
            cnt <= cur_period - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Marks whether a bit is being sent; drops at a stalled boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            sending <= 1'b0;
        end else if (cnt == '0) begin
            sending <= bit_valid;
        end
    end

endmodule

// File: rtl/fsk_tone_step.sv
`timescale 1ns/1ps
// fsk_tone_step: holds the phase step for the bit being sent. It loads
// a new step only when a bit is accepted.
// Assumes tone frequencies are in 0.1 Hz units and lie below CLK_HZ/2.
module fsk_tone_step
    import fsk_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned MARK_DHZ   = 1_333_000,
    parameter int unsigned SPACE0_DHZ = 1_318_000,
    parameter int unsigned SPACE1_DHZ = 1_304_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_load,
    input  logic             bit_data,
    input  logic             space_alt,
    output logic [ACC_W-1:0] step
);

    localparam logic [ACC_W-1:0] STEP_MARK =
        ACC_W'(phase_step(64'(MARK_DHZ), 64'(CLK_HZ), ACC_W));

    logic [ACC_W-1:0] space_tbl [2];

    // Steps for the two selectable low tones.
    for (genvar g = 0; g < 2; g++) begin : g_space
        localparam int unsigned F_DHZ = (g == 0) ? SPACE0_DHZ : SPACE1_DHZ;
        assign space_tbl[g] = ACC_W'(phase_step(64'(F_DHZ), 64'(CLK_HZ), ACC_W));
    end

    // Load the step for each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (bit_load) begin
            step <= bit_data ? STEP_MARK : space_tbl[space_alt];
        end
    end

endmodule

// File: rtl/fsk_phase_acc.sv
`timescale 1ns/1ps
// fsk_phase_acc: phase accumulator that wraps modulo 2^ACC_W.
// Assumes clear has priority over advance.
module fsk_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc
);

    // Advance or clear the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (advance) begin
            acc <= acc + step;
        end
    end

endmodule

// File: rtl/fsk_mod.sv
`timescale 1ns/1ps
// fsk_mod: two-tone FSK modulator top. It ties together the
// configuration latch, the bit timer, the tone step register and the
// phase accumulator. The output is the top bit of the accumulator.
// Assumes CLK_HZ is well above twice the highest tone.
module fsk_mod
    import fsk_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int unsigned BASE_BPS   = 600,
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned MARK_DHZ   = 1_333_000,
    parameter int unsigned SPACE0_DHZ = 1_318_000,
    parameter int unsigned SPACE1_DHZ = 1_304_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       bit_valid,
    input  logic       bit_data,
    output logic       bit_ready,
    input  logic [1:0] rate_sel,
    input  logic       tone_sel,
    output logic       fsk_out
);

    localparam int unsigned NUM_RATES = 4;
    localparam int unsigned RIDX_W    = $clog2(NUM_RATES);
    localparam int unsigned CNT_W     = $clog2(CLK_HZ / BASE_BPS + 1);

    fsk_cfg_t         cfg_q;
    logic             bit_load;
    logic             sending;
    logic [CNT_W-1:0] bit_cnt;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase_acc;

    fsk_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .rate_sel (rate_sel),
        .tone_sel (tone_sel),
        .cfg_q    (cfg_q)
    );

    fsk_bit_timer #(
        .CLK_HZ    (CLK_HZ),
        .BASE_BPS  (BASE_BPS),
        .NUM_RATES (NUM_RATES),
        .RIDX_W    (RIDX_W),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .rate_idx  (RIDX_W'(cfg_q.rate)),
        .bit_valid (bit_valid),
        .bit_ready (bit_ready),
        .bit_load  (bit_load),
        .sending   (sending),
        .cnt       (bit_cnt)
    );

    fsk_tone_step #(
        .CLK_HZ     (CLK_HZ),
        .ACC_W      (ACC_W),
        .MARK_DHZ   (MARK_DHZ),
        .SPACE0_DHZ (SPACE0_DHZ),
        .SPACE1_DHZ (SPACE1_DHZ)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_load  (bit_load),
        .bit_data  (bit_data),
        .space_alt (cfg_q.space_alt),
        .step      (step)
    );

    fsk_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!tx_en),
        .advance (sending),
        .step    (step),
        .acc     (phase_acc)
    );

    // Carrier is the accumulator's top bit.
    assign fsk_out = phase_acc[ACC_W-1];

endmodule

// File: rtl/fsk_mod_chk.sv
`timescale 1ns/1ps
// fsk_mod_chk: temporal checks on the modulator, bound into fsk_mod.
module fsk_mod_chk
    import fsk_pkg::*;
#(
    parameter int unsigned CNT_W = 18,
    parameter int unsigned ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             bit_valid,
    input logic             bit_ready,
    input logic             fsk_out,
    input fsk_cfg_t         cfg_q,
    input logic             sending,
    input logic [CNT_W-1:0] cnt,
    input logic [ACC_W-1:0] acc
);

    p_single_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ready && bit_valid) |=> !bit_ready);

    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    p_hold_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !sending) |=> $stable(acc));

    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!fsk_out && acc == '0));

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(cfg_q));

endmodule

bind fsk_mod fsk_mod_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .fsk_out   (fsk_out),
    .cfg_q     (cfg_q),
    .sending   (sending),
    .cnt       (bit_cnt),
    .acc       (phase_acc)
);

// File: tb/sim_fsk_mod.sv
`timescale 1ns/1ps
// sim_fsk_mod: scoreboard bench. The driver queues the period and step
// expected for each offered bit. The monitor takes one entry from the
// queue at each accepted bit and checks the output and ready on every
// cycle.
module sim_fsk_mod;

    localparam int unsigned CLK_HZ = 1_200_000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en;
    logic       bit_valid;
    logic       bit_data;
    logic       bit_ready;
    logic [1:0] rate_sel;
    logic       tone_sel;
    logic       fsk_out;

    always #4 clk = ~clk;

    fsk_mod #(.CLK_HZ(CLK_HZ)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_ready (bit_ready),
        .rate_sel  (rate_sel),
        .tone_sel  (tone_sel),
        .fsk_out   (fsk_out)
    );

    typedef struct {
        int unsigned period;
        logic [31:0] step;
    } item_t;

    item_t       exp_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          mon_en = 1'b0;
    bit          tx_prev;
    logic [31:0] m_acc;
    logic [31:0] m_step;
    int unsigned rem;

    // Step from the rounding rule in R3 (f in 0.1 Hz units).
    function automatic logic [31:0] step_of(input longint unsigned f_dhz);
        return 32'(((f_dhz << 32) + 64'd5 * CLK_HZ) / (64'd10 * CLK_HZ));
    endfunction

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: compare this cycle, then model the next clock edge.
    always @(negedge clk) begin
        if (mon_en) begin
            chk(fsk_out === m_acc[31],
                tx_prev ? "R3 R4 carrier phase" : "R6 idle output",
                fsk_out, m_acc[31]);
            chk(bit_ready === (tx_en && rem <= 1),
                (rem == 0) ? "R5 ready at boundary" : "R2 ready spacing",
                bit_ready, (tx_en && rem <= 1));
            if (!tx_en) begin
                m_acc = '0;
                rem   = 0;
            end else begin
                if (rem > 0) begin
                    m_acc = m_acc + m_step;
                    rem   = rem - 1;
                end
                if (bit_ready && bit_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected accept", 1, 0);
                    end else begin
                        item_t it;
                        it     = exp_q.pop_front();
                        m_step = it.step;
                        rem    = it.period;
                    end
                end
            end
            tx_prev = tx_en;
        end
    end

    task automatic offer_bit(input bit d, input int unsigned per, input logic [31:0] stp);
        item_t it;
        it.period = per;
        it.step   = stp;
        exp_q.push_back(it);
        bit_valid = 1'b1;
        bit_data  = d;
        do @(negedge clk); while (!bit_ready);
        @(posedge clk);
        #1;
        bit_valid = 1'b0;
    endtask

    // Sends a packet; the configuration inputs are flipped after the
    // first bit to check that they are ignored (R7).
    task automatic run_packet(input int unsigned rate, input bit alt, input int n,
                              input logic [15:0] pat, input int gap,
                              input bit abort, input bit keep_en);
        int unsigned per;
        logic [31:0] s_mark;
        logic [31:0] s_low;
        per    = CLK_HZ / (600 * (rate + 1));
        s_mark = step_of(64'd1_333_000);
        s_low  = alt ? step_of(64'd1_304_000) : step_of(64'd1_318_000);
        if (!keep_en) begin
            rate_sel = 2'(rate);
            tone_sel = alt;
            repeat (3) @(posedge clk);
            #1;
            tx_en = 1'b1;
        end
        for (int i = 0; i < n; i++) begin
            offer_bit(pat[i], per, pat[i] ? s_mark : s_low);
            if (i == 0) begin
                rate_sel = 2'(3 - rate);
                tone_sel = ~alt;
            end
            repeat (gap) @(posedge clk);
            #1;
        end
        if (abort) repeat (per / 2) @(posedge clk);
        else       repeat (per + 20) @(posedge clk);
        #1;
        tx_en = 1'b0;
        repeat (10) @(posedge clk);
        #1;
    endtask

    // Watchdog.
    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        tx_en     = 1'b0;
        bit_valid = 1'b0;
        bit_data  = 1'b0;
        rate_sel  = 2'd0;
        tone_sel  = 1'b0;
        m_acc     = '0;
        m_step    = '0;
        rem       = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(fsk_out === 1'b0, "R1 reset output", fsk_out, 0);
        chk(bit_ready === 1'b0, "R1 reset ready", bit_ready, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        tx_prev = 1'b0;
        mon_en  = 1'b1;

        run_packet(0, 1'b0, 5, 16'b01101, 0, 1'b0, 1'b0);   // R2 R3 600 bit/s
        run_packet(1, 1'b1, 6, 16'b110010, 0, 1'b0, 1'b0);  // R3 alternate low tone
        run_packet(2, 1'b0, 4, 16'b1001, 700, 1'b0, 1'b0);  // R5 stalls, 1800 bit/s
        run_packet(3, 1'b1, 8, 16'b10110100, 0, 1'b0, 1'b0); // R4 phase continuity
        run_packet(3, 1'b0, 3, 16'b011, 0, 1'b1, 1'b0);     // R6 abort mid-bit
        run_packet(1, 1'b0, 3, 16'b100, 0, 1'b0, 1'b0);     // R6 restart at phase 0

        // R1 default configuration with tx_en held high through reset.
        mon_en = 1'b0;
        rst_n  = 1'b0;
        rate_sel = 2'd0;
        tone_sel = 1'b1;
        tx_en  = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n   = 1'b1;
        m_acc   = '0;
        rem     = 0;
        tx_prev = 1'b1;
        mon_en  = 1'b1;
        run_packet(3, 1'b0, 4, 16'b0110, 0, 1'b0, 1'b1);

        mon_en = 1'b0;
        chk(exp_q.size() == 0, "R2 all offered bits accepted", exp_q.size(), 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule